// File: doc/BRIEF.md
# Rotate-and-Mask Field Shifter

This block is a purely combinational 32-bit field shifter. It rotates a source word left or right by a 5-bit amount. It then clears every bit that falls outside a keep mask. The keep mask is built from two parts. The first is an end mask: its index selects how many low bits are set, and an invert control can complement it. The second is a shift mask, whose width follows the rotate amount.

Two modes are supported. In extract mode both masks are applied as they are. In insert mode the shift mask is complemented before it is combined with the end mask. In both modes the bits that are not kept come out as zero. A register-operand form supplies the rotate amount as a plain value. With that form, a zero end index can take the end mask from a separate mask word instead of generating it.

The block sits in an execution datapath between operand read and result write-back. Its result is valid in the same cycle as its operands.

Top module: `rmf_shifter`

## Requirements
- R1: With `rotRight`=0 the source is rotated left by `rotAmt` bit positions. Bit i moves to bit (i+rotAmt) mod 32.
- R2: With `rotRight`=1 the source is rotated right by `rotAmt` bit positions. Bit i moves to bit (i-rotAmt) mod 32.
- R3: For a nonzero `endIdx` of n, the end mask has bits n-1..0 set and all higher bits clear. For `endIdx`=0 with `useRegMask`=0, the end mask is all ones.
- R4: With `invEnd`=1 the end mask is complemented before it is used.
- R5: The shift-mask index is `rotAmt` for a left rotate and 32-`rotAmt` for a right rotate. A mask of index n has its n low bits set, and an index of 0 or 32 gives all ones.
- R6: With `insertMode`=0 (extract), `result` is the rotated word ANDed with the end mask and the shift mask.
- R7: With `insertMode`=1 (insert), `result` is the rotated word ANDed with the end mask and with the complement of the shift mask.
- R8: With `endIdx`=0 and `useRegMask`=1, the end mask is `regMask`. It is still subject to `invEnd`.
- R9: `regMask` has no effect on `result` when `endIdx` is nonzero or when `useRegMask`=0.
- R10: A `rotAmt` of 0 passes the source unrotated. In extract mode with `endIdx`=0, `invEnd`=0 and `useRegMask`=0, `result` then equals `srcWord`.
- R11: The block has no storage. `result` reflects the current inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcWord | input | 32 | Word to rotate |
| rotAmt | input | 5 | Rotate amount in bit positions |
| endIdx | input | 5 | End-mask index (0 selects full or register mask) |
| rotRight | input | 1 | 1 rotates right, 0 rotates left |
| invEnd | input | 1 | Complements the end mask |
| insertMode | input | 1 | 0 extract, 1 insert |
| useRegMask | input | 1 | Take the end mask from regMask when endIdx is 0 |
| regMask | input | 32 | Register-supplied end mask |
| result | output | 32 | Rotated and masked word |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between any input and `result`. The bench applies each operand set just after a rising edge. It samples `result` at the following falling edge, half a period later, so that every check falls within the same cycle as its stimulus. Directed corners cover rotate amounts of zero, masks in both modes, inversion, and whether the register mask takes effect. A seeded random sweep then compares each result against a bit-level reference function.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  parameter int WORD_W = 32;
  localparam int IDX_W = $clog2(WORD_W);

  // strobes handed from control to datapath
  typedef struct packed {
    logic [IDX_W-1:0]  rightAmt;  // rotate amount normalised to a right rotate
    logic [WORD_W-1:0] keepMask;  // bits that survive
  } rmf_ctrl_t;

  // n low bits set; callers map index 0 to a full mask
  function automatic logic [WORD_W-1:0] lowMask(input logic [IDX_W-1:0] n);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/rmf_ctrl.sv
module rmf_ctrl
  import rmf_pkg::*;
(
  input  logic [IDX_W-1:0]  rotAmt,
  input  logic [IDX_W-1:0]  endIdx,
  input  logic              rotRight,
  input  logic              invEnd,
  input  logic              insertMode,
  input  logic              useRegMask,
  input  logic [WORD_W-1:0] regMask,
  output rmf_ctrl_t         ctrl
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic [IDX_W-1:0]  shiftIdx;
  logic [WORD_W-1:0] rawEnd;
  logic [WORD_W-1:0] endMask;
  logic [WORD_W-1:0] shiftMask;

  always_comb begin
    // modulo WORD_W arithmetic: 32-rot truncates to 0 when rot is 0
    shiftIdx = rotRight ? IDX_W'(0) - rotAmt : rotAmt;
    if (endIdx != '0)    rawEnd = lowMask(endIdx);
    else if (useRegMask) rawEnd = regMask;
    else                 rawEnd = ALL_ONES;
    endMask   = invEnd ? ~rawEnd : rawEnd;
    shiftMask = (shiftIdx == '0) ? ALL_ONES : lowMask(shiftIdx);

    ctrl.rightAmt = rotRight ? rotAmt : IDX_W'(0) - rotAmt;
    ctrl.keepMask = insertMode ? (endMask & ~shiftMask) : (endMask & shiftMask);
  end

  always_comb begin
    if (rotRight)
      AST_SHIFT_WIDTH: assert ($countones(shiftMask) ==
                               ((rotAmt == '0) ? WORD_W : WORD_W - int'(rotAmt))); // R5
    if (insertMode && rotAmt == '0)
      AST_INSERT_ROT0_EMPTY: assert (ctrl.keepMask == '0); // R7
    if (endIdx != '0 && !invEnd)
      AST_END_WIDTH: assert ($countones(endMask) == int'(endIdx)); // R3
  end
endmodule

// File: rtl/rmf_datapath.sv
module rmf_datapath
  import rmf_pkg::*;
(
  input  logic [WORD_W-1:0] srcWord,
  input  rmf_ctrl_t         ctrl,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] stage [IDX_W+1];

  assign stage[0] = srcWord;

  // logarithmic right rotator, one stage per amount bit
  for (genvar k = 0; k < IDX_W; k++) begin : g_rot
    localparam int STEP = 1 << k;
    assign stage[k+1] = ctrl.rightAmt[k]
                      ? {stage[k][STEP-1:0], stage[k][WORD_W-1:STEP]}
                      : stage[k];
  end

  assign result = stage[IDX_W] & ctrl.keepMask;

  always_comb begin
    if (ctrl.rightAmt == '0)
      AST_ROT_ZERO_PASS: assert (stage[IDX_W] == srcWord); // R10
    AST_MASK_RESPECTED: assert ((result & ~ctrl.keepMask) == '0); // R6
    AST_POPCOUNT_KEPT: assert ($countones(stage[IDX_W]) == $countones(srcWord)); // R1
  end
endmodule

// File: rtl/rmf_shifter.sv
module rmf_shifter
  import rmf_pkg::*;
(
  input  logic [31:0] srcWord,
  input  logic [4:0]  rotAmt,
  input  logic [4:0]  endIdx,
  input  logic        rotRight,
  input  logic        invEnd,
  input  logic        insertMode,
  input  logic        useRegMask,
  input  logic [31:0] regMask,
  output logic [31:0] result
);
  rmf_ctrl_t ctrlStrobes;

  rmf_ctrl u_ctrl (
    .rotAmt     (rotAmt),
    .endIdx     (endIdx),
    .rotRight   (rotRight),
    .invEnd     (invEnd),
    .insertMode (insertMode),
    .useRegMask (useRegMask),
    .regMask    (regMask),
    .ctrl       (ctrlStrobes)
  );

  rmf_datapath u_dp (
    .srcWord (srcWord),
    .ctrl    (ctrlStrobes),
    .result  (result)
  );
endmodule

// File: tb/rmf_shifter_tb.sv
module rmf_shifter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [31:0] srcWord = '0, regMask = '0;
  logic [4:0]  rotAmt = '0, endIdx = '0;
  logic        rotRight = 1'b0, invEnd = 1'b0, insertMode = 1'b0, useRegMask = 1'b0;
  logic [31:0] result;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  rmf_shifter u_dut (
    .srcWord(srcWord), .rotAmt(rotAmt), .endIdx(endIdx), .rotRight(rotRight),
    .invEnd(invEnd), .insertMode(insertMode), .useRegMask(useRegMask),
    .regMask(regMask), .result(result)
  );

  function automatic logic [31:0] nBits(int n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [31:0] model(logic [31:0] s, int r, int e, bit rt,
                                       bit inv, bit ins, bit ur, logic [31:0] rm);
    logic [31:0] rot, em, sm;
    int si;
    for (int i = 0; i < 32; i++)
      if (rt) rot[i] = s[(i + r) % 32];
      else    rot[i] = s[(i - r + 32) % 32];
    if (e != 0) em = nBits(e);
    else        em = ur ? rm : 32'hFFFF_FFFF;
    if (inv) em = ~em;
    si = rt ? (32 - r) : r;
    sm = (si == 0 || si == 32) ? 32'hFFFF_FFFF : nBits(si);
    return ins ? (rot & em & ~sm) : (rot & em & sm);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] s, int r, int e, bit rt, bit inv,
                     bit ins, bit ur, logic [31:0] rm, logic [31:0] exp);
    @(posedge clk);
    srcWord = s; rotAmt = 5'(r); endIdx = 5'(e); rotRight = rt; invEnd = inv;
    insertMode = ins; useRegMask = ur; regMask = rm;
    @(negedge clk);  // same cycle: no register on the path (R11)
    check(tag, result, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset state", result, 32'h0);
    rstN = 1'b1;
    run("R1 left rot 4",        32'h12345678, 4, 0, 0, 0, 0, 0, 0, 32'h00000001);
    run("R2 right rot 8",       32'h12345678, 8, 0, 1, 0, 0, 0, 0, 32'h00123456);
    run("R3 end index 8",       32'h12345678, 0, 8, 0, 0, 0, 0, 0, 32'h00000078);
    run("R4 inverted end",      32'h12345678, 0, 8, 0, 1, 0, 0, 0, 32'h12345600);
    run("R5 right rot 0 full",  32'hA5A5A5A5, 0, 0, 1, 0, 0, 0, 0, 32'hA5A5A5A5);
    run("R6 extract both masks",32'hFFFFFFFF, 12, 4, 0, 0, 0, 0, 0, 32'h0000000F);
    run("R7 insert left 8",     32'h12345678, 8, 0, 0, 0, 1, 0, 0, 32'h34567800);
    run("R8 register mask",     32'h12345678, 0, 0, 0, 0, 0, 1, 32'h0F0F0F0F, 32'h02040608);
    run("R8 inverted reg mask", 32'h12345678, 0, 0, 0, 1, 0, 1, 32'h0F0F0F0F, 32'h10305070);
    run("R9 reg mask ignored",  32'h12345678, 0, 8, 0, 0, 0, 1, 32'h0F0F0F0F, 32'h00000078);
    run("R9 reg mask disabled", 32'h12345678, 0, 0, 0, 0, 0, 0, 32'h0F0F0F0F, 32'h12345678);
    run("R10 rot 0 passthrough",32'hDEADBEEF, 0, 0, 0, 0, 0, 0, 0, 32'hDEADBEEF);
    run("R7 insert right 4",    32'h12345678, 4, 0, 1, 0, 1, 0, 0, 32'h80000000);
    void'($urandom(32'd2718));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] s, rm;
      int r, e;
      bit rt, inv, ins, ur;
      s = $urandom; rm = $urandom; r = $urandom % 32; e = $urandom % 32;
      if (n % 5 == 0) r = 0;
      if (n % 7 == 0) e = 0;
      rt = 1'($urandom); inv = 1'($urandom); ins = 1'($urandom); ur = 1'($urandom);
      run(ins ? "R7 random insert" : "R6 random extract", s, r, e, rt, inv, ins, ur, rm,
          model(s, r, e, rt, inv, ins, ur, rm));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule